// File: doc/BRIEF.md
# Address-Matched Multi-Channel Receive DMA

This block sits between an on-chip interconnect and a processor's local shared memory. Each incoming word carries a bus address. The block compares that address against eight receive channels. Each channel has a memory destination, a bus address to claim and a word budget. A word that an enabled channel claims goes straight to memory at that channel's next destination address, with no processor involvement. A channel's budget may be filled by any number of separate packets. When the last budgeted word has been stored, the channel turns itself off and flags completion.

Software reaches the block through a simple register port. It programs a channel's three values, arms the channel with a one-hot write, and sets a global interrupt enable. A word that no armed channel claims is not dropped. The block takes it into a one-word holding slot, flags an unknown-address event and stalls the interconnect. Software can then read the stalled address, acknowledge the event and, whenever it likes, arm a channel for that address. The held word then drains into that channel and traffic resumes.

Top module: `rx_match_dma`

## Requirements
- R1: After reset, irq, memWe and every register read are 0, inReady is 1 and every channel is disarmed.
- R2: Channel c owns register word offsets c*16+0 (destination memory address), c*16+1 (bus address to claim) and c*16+2 (words still to receive). All three read back. The destination and remaining values track progress.
- R3: Writing offset 5 with bit c set arms channel c when its remaining count is nonzero. Arming a channel whose count is zero has no effect. Reading offset 5 returns the mask of armed channels.
- R4: An accepted word (inValid and inReady both high at a clock edge) whose address equals an armed channel's claim address appears on memWe/memAddr/memWdata in the following cycle. The address used is the channel's destination, and the destination then advances by one.
- R5: A channel's count may be met across several packets separated by idle cycles. When the remaining count reaches zero the channel disarms, and later words for its address count as unclaimed.
- R6: The cycle after a channel's final word is presented to memory, status bit c (offset 6) is set. irq equals bit 1 of offset 4 ANDed with the OR of all status bits.
- R7: Writing offset 6 clears each status bit written as one and leaves the others untouched.
- R8: An accepted word that no armed channel claims is not written to memory. It sets status bit 8, its address becomes readable at offset 7, and inReady stays low until the word is released, even after bit 8 is acknowledged.
- R9: Once a channel claiming the held address is armed, the held word is written to that channel's destination, inReady returns high and the channel continues counting from there.
- R10: When several armed channels claim the same address, the lowest-numbered one receives the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 7 | Register word address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| inValid | input | 1 | Incoming word present |
| inAddr | input | 16 | Bus address tag of the incoming word |
| inData | input | 32 | Incoming word |
| inReady | output | 1 | Block can take a word this cycle |
| memWe | output | 1 | Shared memory write strobe |
| memAddr | output | 16 | Shared memory word address |
| memWdata | output | 32 | Shared memory write data |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check several orderings. Each memory write must follow an accepted or held word. A parked word never produces a write in the cycle it is parked. Releasing the held word always coincides with a write. Store and park are never issued together. A channel's status flag only rises right after a memory write, and a disarming channel always raises its flag one cycle later. The contents of memory writes can only be shown by the bench's scenarios: the exact addresses across packet gaps, the lowest-index choice between overlapping channels, the effect of the interrupt enable, acknowledge behaviour, and the deferred delivery of a parked word after late configuration.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  localparam int NUM_CH = 8;
  localparam int CH_W = $clog2(NUM_CH);
  localparam int STAT_W = NUM_CH + 1;
  localparam int UNK_BIT = NUM_CH;
  localparam int GRP_SHIFT = 4;

  localparam logic [GRP_SHIFT-1:0] OFF_CTRL    = 4'd4;
  localparam logic [GRP_SHIFT-1:0] OFF_ARM     = 4'd5;
  localparam logic [GRP_SHIFT-1:0] OFF_STATUS  = 4'd6;
  localparam logic [GRP_SHIFT-1:0] OFF_UNKNOWN = 4'd7;
  localparam int IRQ_EN_BIT = 1;

  typedef enum logic [1:0] {
    FLD_DEST  = 2'd0,
    FLD_MATCH = 2'd1,
    FLD_COUNT = 2'd2,
    FLD_NONE  = 2'd3
  } cfgField_e;

  typedef struct packed {
    logic            store;
    logic            fromHold;
    logic [CH_W-1:0] chan;
    logic            park;
    logic            cfgWe;
    cfgField_e       cfgField;
    logic [CH_W-1:0] cfgChan;
  } rxStrobe_t;

  function automatic logic [CH_W-1:0] lowestSet(input logic [NUM_CH-1:0] vec);
    logic [CH_W-1:0] idx;
    idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (vec[i]) idx = CH_W'(i);
    end
    return idx;
  endfunction
endpackage

// File: rtl/rxdma_ctrl.sv
module rxdma_ctrl
  import rxdma_pkg::*;
#(
  parameter int DW = 32,
  parameter int REG_AW = CH_W + GRP_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DW-1:0]     regWdata,
  input  logic              inValid,
  input  logic [NUM_CH-1:0] inHit,
  input  logic [NUM_CH-1:0] holdHit,
  input  logic [NUM_CH-1:0] lastVec,
  input  logic [NUM_CH-1:0] cntNonZero,
  input  logic              memLast,
  input  logic [CH_W-1:0]   memChan,
  output logic              inReady,
  output logic              holdValid,
  output logic              irq,
  output logic              irqEn,
  output logic [NUM_CH-1:0] enMask,
  output logic [STAT_W-1:0] status,
  output rxStrobe_t         stb
);
  logic [CH_W-1:0]      chanIdx;
  logic [GRP_SHIFT-1:0] offset;
  logic                 globalWr;
  logic                 wrCtrl, wrArm, wrStatus;
  logic [NUM_CH-1:0]    inHitEn, holdHitEn;
  logic                 accept;
  logic [NUM_CH-1:0]    enNext;
  logic [STAT_W-1:0]    statusNext;

  assign chanIdx  = regAddr[REG_AW-1:GRP_SHIFT];
  assign offset   = regAddr[GRP_SHIFT-1:0];
  assign globalWr = regWe && (chanIdx == '0);
  assign wrCtrl   = globalWr && (offset == OFF_CTRL);
  assign wrArm    = globalWr && (offset == OFF_ARM);
  assign wrStatus = globalWr && (offset == OFF_STATUS);

  assign inReady   = !holdValid;
  assign accept    = inValid && inReady;
  assign inHitEn   = inHit & enMask;
  assign holdHitEn = holdHit & enMask;

  // Decide what the datapath does this cycle
  always_comb begin
    stb = '0;
    stb.cfgField = FLD_NONE;
    if (holdValid && (|holdHitEn)) begin
      stb.store    = 1'b1;
      stb.fromHold = 1'b1;
      stb.chan     = lowestSet(holdHitEn);
    end else if (accept) begin
      if (|inHitEn) begin
        stb.store = 1'b1;
        stb.chan  = lowestSet(inHitEn);
      end else begin
        stb.park = 1'b1;
      end
    end
    if (regWe) begin
      stb.cfgChan = chanIdx;
      unique case (offset)
        4'd0: begin stb.cfgWe = 1'b1; stb.cfgField = FLD_DEST; end
        4'd1: begin stb.cfgWe = 1'b1; stb.cfgField = FLD_MATCH; end
        4'd2: begin stb.cfgWe = 1'b1; stb.cfgField = FLD_COUNT; end
        default: ;
      endcase
    end
  end

  always_comb begin
    enNext = enMask;
    if (stb.store && lastVec[stb.chan]) enNext[stb.chan] = 1'b0;
    if (wrArm) enNext = enNext | (regWdata[NUM_CH-1:0] & cntNonZero);
  end

  always_comb begin
    statusNext = status;
    if (wrStatus) statusNext = statusNext & ~regWdata[STAT_W-1:0];
    if (memLast) statusNext[memChan] = 1'b1;
    if (stb.park) statusNext[UNK_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enMask    <= '0;
      status    <= '0;
      irqEn     <= 1'b0;
      holdValid <= 1'b0;
    end else begin
      enMask <= enNext;
      status <= statusNext;
      if (wrCtrl) irqEn <= regWdata[IRQ_EN_BIT];
      if (stb.park) holdValid <= 1'b1;
      else if (stb.store && stb.fromHold) holdValid <= 1'b0;
    end
  end

  assign irq = irqEn && (|status);
endmodule

// File: rtl/rxdma_datapath.sv
module rxdma_datapath
  import rxdma_pkg::*;
#(
  parameter int DW = 32,
  parameter int MEM_AW = 16,
  parameter int BUS_AW = 16,
  parameter int CNT_W = 16,
  parameter int REG_AW = CH_W + GRP_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         stb,
  input  logic [BUS_AW-1:0] inAddr,
  input  logic [DW-1:0]     inData,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DW-1:0]     regWdata,
  input  logic [NUM_CH-1:0] enMask,
  input  logic [STAT_W-1:0] status,
  input  logic              irqEn,
  output logic [NUM_CH-1:0] inHit,
  output logic [NUM_CH-1:0] holdHit,
  output logic [NUM_CH-1:0] lastVec,
  output logic [NUM_CH-1:0] cntNonZero,
  output logic              memWe,
  output logic [MEM_AW-1:0] memAddr,
  output logic [DW-1:0]     memWdata,
  output logic              memLast,
  output logic [CH_W-1:0]   memChan,
  output logic [DW-1:0]     regRdata
);
  logic [MEM_AW-1:0] destQ  [NUM_CH];
  logic [BUS_AW-1:0] matchQ [NUM_CH];
  logic [CNT_W-1:0]  remQ   [NUM_CH];
  logic [BUS_AW-1:0] holdAddr;
  logic [DW-1:0]     holdData;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
    assign inHit[c]      = (matchQ[c] == inAddr);
    assign holdHit[c]    = (matchQ[c] == holdAddr);
    assign lastVec[c]    = (remQ[c] == CNT_W'(1));
    assign cntNonZero[c] = (remQ[c] != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) begin
        destQ[c]  <= '0;
        matchQ[c] <= '0;
        remQ[c]   <= '0;
      end
      holdAddr <= '0;
      holdData <= '0;
      memWe    <= 1'b0;
      memLast  <= 1'b0;
      memAddr  <= '0;
      memWdata <= '0;
      memChan  <= '0;
    end else begin
      memWe   <= stb.store;
      memLast <= stb.store && lastVec[stb.chan];
      if (stb.store) begin
        memAddr  <= destQ[stb.chan];
        memWdata <= stb.fromHold ? holdData : inData;
        memChan  <= stb.chan;
        destQ[stb.chan] <= destQ[stb.chan] + MEM_AW'(1);
        remQ[stb.chan]  <= remQ[stb.chan] - CNT_W'(1);
      end
      if (stb.park) begin
        holdAddr <= inAddr;
        holdData <= inData;
      end
      if (stb.cfgWe) begin
        unique case (stb.cfgField)
          FLD_DEST:  destQ[stb.cfgChan]  <= regWdata[MEM_AW-1:0];
          FLD_MATCH: matchQ[stb.cfgChan] <= regWdata[BUS_AW-1:0];
          FLD_COUNT: remQ[stb.cfgChan]   <= regWdata[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  // Register read mux
  logic [CH_W-1:0]      rdChan;
  logic [GRP_SHIFT-1:0] rdOff;
  assign rdChan = regAddr[REG_AW-1:GRP_SHIFT];
  assign rdOff  = regAddr[GRP_SHIFT-1:0];

  always_comb begin
    regRdata = '0;
    unique case (rdOff)
      4'd0: regRdata = DW'(destQ[rdChan]);
      4'd1: regRdata = DW'(matchQ[rdChan]);
      4'd2: regRdata = DW'(remQ[rdChan]);
      OFF_CTRL:    if (rdChan == '0) regRdata[IRQ_EN_BIT] = irqEn;
      OFF_ARM:     if (rdChan == '0) regRdata = DW'(enMask);
      OFF_STATUS:  if (rdChan == '0) regRdata = DW'(status);
      OFF_UNKNOWN: if (rdChan == '0) regRdata = DW'(holdAddr);
      default: ;
    endcase
  end
endmodule

// File: rtl/rx_match_dma.sv
module rx_match_dma
  import rxdma_pkg::*;
#(
  parameter int DW = 32,
  parameter int MEM_AW = 16,
  parameter int BUS_AW = 16,
  parameter int CNT_W = 16,
  parameter int REG_AW = CH_W + GRP_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DW-1:0]     regWdata,
  output logic [DW-1:0]     regRdata,
  input  logic              inValid,
  input  logic [BUS_AW-1:0] inAddr,
  input  logic [DW-1:0]     inData,
  output logic              inReady,
  output logic              memWe,
  output logic [MEM_AW-1:0] memAddr,
  output logic [DW-1:0]     memWdata,
  output logic              irq
);
  rxStrobe_t         stb;
  logic [NUM_CH-1:0] inHit, holdHit, lastVec, cntNonZero, enMask;
  logic [STAT_W-1:0] status;
  logic              irqEn, holdValid, memLast;
  logic [CH_W-1:0]   memChan;

  rxdma_ctrl #(.DW(DW), .REG_AW(REG_AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .inValid(inValid), .inHit(inHit), .holdHit(holdHit), .lastVec(lastVec),
    .cntNonZero(cntNonZero), .memLast(memLast), .memChan(memChan),
    .inReady(inReady), .holdValid(holdValid), .irq(irq), .irqEn(irqEn),
    .enMask(enMask), .status(status), .stb(stb)
  );

  rxdma_datapath #(.DW(DW), .MEM_AW(MEM_AW), .BUS_AW(BUS_AW), .CNT_W(CNT_W),
                   .REG_AW(REG_AW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .inAddr(inAddr), .inData(inData),
    .regAddr(regAddr), .regWdata(regWdata), .enMask(enMask), .status(status),
    .irqEn(irqEn), .inHit(inHit), .holdHit(holdHit), .lastVec(lastVec),
    .cntNonZero(cntNonZero), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memLast(memLast), .memChan(memChan), .regRdata(regRdata)
  );
endmodule

// File: rtl/rxdma_checker.sv
module rxdma_checker
  import rxdma_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              memWe,
  input logic              holdValid,
  input rxStrobe_t         stb,
  input logic [NUM_CH-1:0] enMask,
  input logic [STAT_W-1:0] status
);
  // R4: a write needs an accepted or a held word behind it
  a_r4_write_has_source: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> ($past(inValid && inReady) || $past(holdValid)));

  // R8: parking consumes a word without writing it
  a_r8_park_no_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdValid) |-> (!memWe && $past(inValid && inReady)));

  // R9: releasing the held word always produces a write
  a_r9_release_writes: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdValid) |-> memWe);

  // R10: one decision per cycle
  a_r10_store_park_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.store && stb.park));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    // R6: completion flag only follows a memory write
    a_r6_flag_after_write: assert property (@(posedge clk) disable iff (!rstN)
      $rose(status[c]) |-> $past(memWe));
    // R5: disarming is always followed by the completion flag
    a_r5_disarm_flags: assert property (@(posedge clk) disable iff (!rstN)
      $fell(enMask[c]) |=> status[c]);
  end
endmodule

bind rx_match_dma rxdma_checker u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .memWe(memWe),
  .holdValid(holdValid), .stb(stb), .enMask(enMask), .status(status)
);

// File: tb/tb_rx_match_dma.sv
`timescale 1ns/1ps
module tb_rx_match_dma;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [6:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        inValid = 1'b0;
  logic [15:0] inAddr = '0;
  logic [31:0] inData = '0;
  logic        inReady, memWe, irq;
  logic [15:0] memAddr;
  logic [31:0] memWdata;

  int checks = 0;
  int fails = 0;
  logic [47:0] expQ[$];

  always #10 clk = ~clk;

  rx_match_dma dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .inValid(inValid), .inAddr(inAddr), .inData(inData),
    .inReady(inReady), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .irq(irq)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Monitor: every memory write is compared with the scoreboard head
  always @(negedge clk) begin
    if (rstN && memWe) begin
      if (expQ.size() == 0) begin
        chk("R4", "unexpected memory write", {16'h0, memAddr, memWdata}, 64'h0);
      end else begin
        logic [47:0] e;
        e = expQ.pop_front();
        chk("R4", "memory write addr/data", {16'h0, memAddr, memWdata}, {16'h0, e});
      end
    end
  end

  task automatic expectWrite(input logic [15:0] a, input logic [31:0] d);
    expQ.push_back({a, d});
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); #1;
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic rdChk(input string req, input logic [6:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, $sformatf("reg %0h", a), {32'h0, v}, {32'h0, exp});
  endtask

  task automatic send(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    inValid = 1'b1; inAddr = a; inData = d;
    @(posedge clk); #1;
    inValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfgChan(input int c, input logic [15:0] dest, input logic [15:0] match, input logic [15:0] cnt);
    wr(7'(c * 16 + 0), {16'h0, dest});
    wr(7'(c * 16 + 1), {16'h0, match});
    wr(7'(c * 16 + 2), {16'h0, cnt});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "irq", {63'h0, irq}, 64'h0);
    chk("R1", "inReady", {63'h0, inReady}, 64'h1);
    chk("R1", "memWe", {63'h0, memWe}, 64'h0);
    rdChk("R1", 7'h05, 32'h0);
    rdChk("R1", 7'h06, 32'h0);
    rdChk("R1", 7'h02, 32'h0);

    // Global interrupt enable by read-modify-write of offset 4 bit 1
    rd(7'h04, v);
    wr(7'h04, v | 32'h2);
    rdChk("R6", 7'h04, 32'h2);

    // Channel 0: three words over two packets (R2, R3, R4, R5)
    cfgChan(0, 16'h0100, 16'h0020, 16'd3);
    rdChk("R2", 7'h01, 32'h20);
    wr(7'h05, 32'h1);
    rdChk("R3", 7'h05, 32'h1);
    expectWrite(16'h0100, 32'hA1);
    send(16'h0020, 32'hA1);
    expectWrite(16'h0101, 32'hA2);
    send(16'h0020, 32'hA2);
    idle(4);
    chk("R5", "irq before count met", {63'h0, irq}, 64'h0);
    rdChk("R2", 7'h02, 32'h1);
    expectWrite(16'h0102, 32'hA3);
    send(16'h0020, 32'hA3);
    idle(3);
    rdChk("R2", 7'h00, 32'h103);
    rdChk("R2", 7'h02, 32'h0);
    rdChk("R5", 7'h05, 32'h0);
    rdChk("R6", 7'h06, 32'h1);
    chk("R6", "irq on completion", {63'h0, irq}, 64'h1);

    // R7 acknowledge
    wr(7'h06, 32'h1);
    rdChk("R7", 7'h06, 32'h0);
    chk("R7", "irq after ack", {63'h0, irq}, 64'h0);

    // R6 gating by the enable bit: channel 3
    wr(7'h04, 32'h0);
    cfgChan(3, 16'h0180, 16'h0033, 16'd1);
    wr(7'h05, 32'h8);
    expectWrite(16'h0180, 32'hB1);
    send(16'h0033, 32'hB1);
    idle(3);
    rdChk("R6", 7'h06, 32'h8);
    chk("R6", "irq gated off", {63'h0, irq}, 64'h0);
    wr(7'h04, 32'h2);
    @(negedge clk);
    chk("R6", "irq ungated", {63'h0, irq}, 64'h1);
    wr(7'h06, 32'h8);

    // R3 arming with zero count has no effect (channel 5)
    wr(7'h05, 32'h20);
    rdChk("R3", 7'h05, 32'h0);

    // R10 priority between channels 1 and 2 claiming the same address
    cfgChan(1, 16'h0200, 16'h0044, 16'd1);
    cfgChan(2, 16'h0300, 16'h0044, 16'd1);
    wr(7'h05, 32'h6);
    expectWrite(16'h0200, 32'hC1);
    send(16'h0044, 32'hC1);
    idle(2);
    rdChk("R10", 7'h05, 32'h4);
    expectWrite(16'h0300, 32'hC2);
    send(16'h0044, 32'hC2);
    idle(3);
    rdChk("R10", 7'h06, 32'h6);
    wr(7'h06, 32'h6);

    // R5/R8: channel 0 is done, so its address is now unclaimed
    send(16'h0020, 32'hD1);
    idle(2);
    chk("R8", "inReady while parked", {63'h0, inReady}, 64'h0);
    rdChk("R8", 7'h06, 32'h100);
    rdChk("R8", 7'h07, 32'h20);
    chk("R8", "irq on unknown", {63'h0, irq}, 64'h1);
    wr(7'h06, 32'h100);
    rdChk("R8", 7'h06, 32'h0);
    chk("R8", "inReady after ack", {63'h0, inReady}, 64'h0);
    chk("R8", "no write while parked", {32'h0, 32'(expQ.size())}, 64'h0);

    // R9: late configuration drains the held word
    cfgChan(6, 16'h0400, 16'h0020, 16'd2);
    expectWrite(16'h0400, 32'hD1);
    wr(7'h05, 32'h40);
    idle(3);
    chk("R9", "inReady released", {63'h0, inReady}, 64'h1);
    rdChk("R9", 7'h62, 32'h1);
    expectWrite(16'h0401, 32'hD2);
    send(16'h0020, 32'hD2);
    idle(3);
    rdChk("R9", 7'h06, 32'h40);
    chk("R9", "irq after drain", {63'h0, irq}, 64'h1);
    chk("R4", "scoreboard drained", {32'h0, 32'(expQ.size())}, 64'h0);
    summary();
  end
endmodule